// File: doc/BRIEF.md
# Network Controller Command and Interrupt Register Bank

This block is the host-visible control and status register bank of a network controller. It is reached over a simple word-addressed bus, with single-cycle writes and a combinational read port. It holds:

- a command register, whose bits start and stop controller operations;
- an interrupt status register, which is cleared by writing ones;
- an interrupt mask register;
- a set of configuration, ring-pointer and tally registers, each with its own write rule.

One level-sensitive interrupt output is asserted whenever a status bit is both set and enabled in the mask.

Some command bits request work from the DMA engines outside this block: transmit, address-filter (CAM) load and receive-resource read. Each of these stays pending until the engine answers on its done input. The request itself is sent as a one-cycle pulse. Timer start and stop commands also produce one-cycle pulses. Status events from the rest of the controller arrive on a set vector and are ORed into the status register.

Register map (word index): 0 command, 1 data config, 2 receive control, 3 transmit control, 4 interrupt mask, 5 interrupt status, 6 to 9 receive-ring pointers, 10 to 12 tally counters, 13 end-of-buffer count, 14 revision, 15 second data config.

Top module: `netc_csr_bank`

## Requirements
- R1: After hardware reset the registers read as follows: command 0x0094 (reset, stop-timer and rx-disable set), mask 0, status 0, end-of-buffer count 0x02F8, revision 0x0004, all others 0. All request pulses are low.
- R2: `irqOut` is high exactly when (mask AND status) is nonzero, evaluated on the register values after each clock edge.
- R3: A status write clears each bit written as 1 and leaves bits written as 0 unchanged. Bits on `statusSet` and bits set by done inputs are ORed in during the same cycle, and a set wins over a clear of the same bit.
- R4: A status write that clears a set receive-buffers-exhausted bit (bit 5) issues a resource-read pulse and marks read-resource (command bit 8) pending, unless a read is already pending.
- R5: The registers apply these write rules:
  - mask bit 15 is stored as 0;
  - transmit control keeps only bits 15:12;
  - receive control keeps only bits 15:5;
  - the four ring pointers drop bit 0;
  - the tally registers store the bitwise inverse of the written value;
  - revision is read-only.
- R6: Data config (kept under mask 0xBFFF) and second data config (kept under mask 0xF017) accept writes only while command bit 7 (reset) is set. At any other time, writes to them leave them unchanged.
- R7: While command bit 7 is set, a command write without bit 7 only clears bit 7. It changes no other bit and issues no pulse.
- R8: Otherwise a command write ORs in the written value masked by 0x03BF, and then applies these clears:
  - rx-enable (bit 3) clears rx-disable (bit 2), and rx-disable clears rx-enable;
  - start-timer (bit 5) clears stop-timer (bit 4), and stop-timer clears start-timer.

  Written bits 5 and 4 give start and stop pulses.
- R9: A command write with bit 7 clears bits 9, 8, 1 and 0, sets bits 7 and 2, and issues no transmit, resource-read or CAM-load pulse.
- R10: Writing transmit (bit 1), read-resource (bit 8) or CAM-load (bit 9) gives a one-cycle request pulse on the next cycle, but only if that bit was not already pending. Writing it again while it is pending gives no pulse.
- R11: `txDone` clears command bit 1 and sets status bit 9. `camDone` clears command bit 9 and sets status bit 12. `rraDone` clears command bit 8. Each takes effect at the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous hardware reset |
| hostWe | input | 1 | Host write strobe |
| hostAddr | input | 4 | Word register index for reads and writes |
| hostWrData | input | 16 | Host write data |
| hostRdData | output | 16 | Read data for `hostAddr` (combinational) |
| txDone | input | 1 | Transmit engine finished |
| camDone | input | 1 | Address-filter load finished |
| rraDone | input | 1 | Receive-resource read finished |
| statusSet | input | 16 | Status events to OR into the status register |
| irqOut | output | 1 | Level interrupt |
| txReqPulse | output | 1 | Transmit request pulse |
| rraReqPulse | output | 1 | Resource-read request pulse |
| camReqPulse | output | 1 | Address-filter load request pulse |
| timerStartPulse | output | 1 | Timer start pulse |
| timerStopPulse | output | 1 | Timer stop pulse |

## Verification
The command register is exercised with three kinds of writes:

- single-bit writes, which show that each bit acts on its own;
- paired writes (rx-enable after rx-disable, stop plus rx-disable), which show that the mutual clears resolve in the right order;
- writes carrying the reset bit, which distinguish the exit-from-reset path from a software reset.

Repeated transmit writes with and without an intervening done separate the first request from a re-request. Random writes made inside reset mode check the per-register masks and inversions against a bench model. After leaving reset, a write to the data config register shows that the reset-only gate closes. Random sequences that mix mask writes, write-one-to-clear status writes and status events track the interrupt level. One write that clears and sets status bits in the same cycle shows that the set wins.

// File: rtl/netc_csr_pkg.sv
package netc_csr_pkg;
  localparam int DATA_W   = 16;
  localparam int NUM_REGS = 16;
  localparam int ADDR_W   = $clog2(NUM_REGS);

  // register indices
  localparam int A_CMD    = 0;
  localparam int A_DCFG   = 1;
  localparam int A_RXCTL  = 2;
  localparam int A_TXCTL  = 3;
  localparam int A_IMASK  = 4;
  localparam int A_ISTAT  = 5;
  localparam int A_RING0  = 6;
  localparam int A_RING3  = 9;
  localparam int A_TALLY0 = 10;
  localparam int A_TALLY2 = 12;
  localparam int A_EOBC   = 13;
  localparam int A_REV    = 14;
  localparam int A_DCFG2  = 15;

  // command bit positions
  localparam int B_HTX   = 0;
  localparam int B_TXP   = 1;
  localparam int B_RXDIS = 2;
  localparam int B_RXEN  = 3;
  localparam int B_STP   = 4;
  localparam int B_ST    = 5;
  localparam int B_RST   = 7;
  localparam int B_RRD   = 8;
  localparam int B_CAM   = 9;

  // status bit positions
  localparam int I_RBE  = 5;
  localparam int I_TXDN = 9;
  localparam int I_CAMD = 12;

  localparam logic [DATA_W-1:0] CMD_OR_MASK  = 16'h03BF;
  localparam logic [DATA_W-1:0] CMD_RST_VAL  = 16'h0094;
  localparam logic [DATA_W-1:0] CMD_SWR_CLR  = 16'h0303;
  localparam logic [DATA_W-1:0] CMD_SWR_SET  = 16'h0084;

  typedef struct packed {
    logic [NUM_REGS-1:0] wrSel;
    logic                txDoneSet;
    logic                camDoneSet;
  } strobe_t;

  function automatic logic [DATA_W-1:0] regWrMask(int idx);
    if (idx == A_DCFG)                       return 16'hBFFF;
    if (idx == A_DCFG2)                      return 16'hF017;
    if (idx == A_RXCTL)                      return 16'hFFE0;
    if (idx == A_TXCTL)                      return 16'hF000;
    if (idx == A_IMASK)                      return 16'h7FFF;
    if (idx >= A_RING0 && idx <= A_RING3)    return 16'hFFFE;
    return 16'hFFFF;
  endfunction

  function automatic bit regInverts(int idx);
    return (idx >= A_TALLY0 && idx <= A_TALLY2);
  endfunction
endpackage

// File: rtl/netc_csr_ctrl.sv
module netc_csr_ctrl
  import netc_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic              txDone,
  input  logic              camDone,
  input  logic              rraDone,
  input  logic              rbeFlag,
  output strobe_t           stb,
  output logic [DATA_W-1:0] cmdQ,
  output logic              txReqPulse,
  output logic              rraReqPulse,
  output logic              camReqPulse,
  output logic              timerStartPulse,
  output logic              timerStopPulse
);
  logic [NUM_REGS-1:0] selVec;
  logic [DATA_W-1:0]   cmdNext, wv;
  logic                txP, rraP, camP, stP, spP;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
    if (i == A_DCFG || i == A_DCFG2) begin : g_rstOnly
      assign selVec[i] = hostWe && (hostAddr == ADDR_W'(i)) && cmdQ[B_RST];
    end else if (i == A_REV) begin : g_ro
      assign selVec[i] = 1'b0;
    end else begin : g_any
      assign selVec[i] = hostWe && (hostAddr == ADDR_W'(i));
    end
  end

  always_comb begin
    stb.wrSel      = selVec;
    stb.txDoneSet  = txDone;
    stb.camDoneSet = camDone;
  end

  always_comb begin
    cmdNext = cmdQ;
    wv      = hostWrData & CMD_OR_MASK;
    txP = 1'b0; rraP = 1'b0; camP = 1'b0; stP = 1'b0; spP = 1'b0;
    if (selVec[A_CMD]) begin
      if (cmdQ[B_RST] && !hostWrData[B_RST]) begin
        cmdNext[B_RST] = 1'b0;
      end else begin
        cmdNext = cmdQ | wv;
        if (wv[B_RXDIS]) cmdNext[B_RXEN]  = 1'b0;
        if (wv[B_RXEN])  cmdNext[B_RXDIS] = 1'b0;
        if (wv[B_STP])   cmdNext[B_ST]    = 1'b0;
        if (wv[B_ST])    cmdNext[B_STP]   = 1'b0;
        spP = wv[B_STP];
        stP = wv[B_ST];
        if (wv[B_RST]) begin
          cmdNext = (cmdNext & ~CMD_SWR_CLR) | CMD_SWR_SET;
        end else begin
          txP  = wv[B_TXP] && !cmdQ[B_TXP];
          rraP = wv[B_RRD] && !cmdQ[B_RRD];
          camP = wv[B_CAM] && !cmdQ[B_CAM];
        end
      end
    end
    if (selVec[A_ISTAT] && hostWrData[I_RBE] && rbeFlag && !cmdQ[B_RRD]) begin
      cmdNext[B_RRD] = 1'b1;
      rraP           = 1'b1;
    end
    if (txDone)  cmdNext[B_TXP] = 1'b0;
    if (camDone) cmdNext[B_CAM] = 1'b0;
    if (rraDone) cmdNext[B_RRD] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdQ            <= CMD_RST_VAL;
      txReqPulse      <= 1'b0;
      rraReqPulse     <= 1'b0;
      camReqPulse     <= 1'b0;
      timerStartPulse <= 1'b0;
      timerStopPulse  <= 1'b0;
    end else begin
      cmdQ            <= cmdNext;
      txReqPulse      <= txP;
      rraReqPulse     <= rraP;
      camReqPulse     <= camP;
      timerStartPulse <= stP;
      timerStopPulse  <= spP;
    end
  end
endmodule

// File: rtl/netc_csr_dp.sv
module netc_csr_dp
  import netc_csr_pkg::*;
#(
  parameter logic [DATA_W-1:0] REV_ID    = 16'h0004,
  parameter logic [DATA_W-1:0] EOBC_INIT = 16'h02F8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] cmdQ,
  input  logic [DATA_W-1:0] statusSet,
  output logic              rbeFlag,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut
);
  logic [DATA_W-1:0] regVal [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    if (i == A_CMD) begin : g_cmd
      assign regVal[i] = cmdQ;
    end else if (i == A_REV) begin : g_rev
      assign regVal[i] = REV_ID;
    end else if (i == A_ISTAT) begin : g_isr
      logic [DATA_W-1:0] q;
      logic [DATA_W-1:0] doneBits;
      always_comb begin
        doneBits = '0;
        doneBits[I_TXDN] = stb.txDoneSet;
        doneBits[I_CAMD] = stb.camDoneSet;
      end
      always_ff @(posedge clk) begin
        if (!rstN) q <= '0;
        else q <= (q & ~(stb.wrSel[i] ? wrData : '0)) | statusSet | doneBits;
      end
      assign regVal[i] = q;
    end else begin : g_std
      localparam logic [DATA_W-1:0] MSK = regWrMask(i);
      localparam bit                INV = regInverts(i);
      localparam logic [DATA_W-1:0] RV  = (i == A_EOBC) ? EOBC_INIT : '0;
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
        if (!rstN) q <= RV;
        else if (stb.wrSel[i]) q <= (INV ? ~wrData : wrData) & MSK;
      end
      assign regVal[i] = q;
    end
  end

  assign rdData  = regVal[rdAddr];
  assign irqOut  = |(regVal[A_IMASK] & regVal[A_ISTAT]);
  assign rbeFlag = regVal[A_ISTAT][I_RBE];
endmodule

// File: rtl/netc_csr_bank.sv
module netc_csr_bank
  import netc_csr_pkg::*;
#(
  parameter logic [15:0] REV_ID    = 16'h0004,
  parameter logic [15:0] EOBC_INIT = 16'h02F8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostWe,
  input  logic [3:0]  hostAddr,
  input  logic [15:0] hostWrData,
  output logic [15:0] hostRdData,
  input  logic        txDone,
  input  logic        camDone,
  input  logic        rraDone,
  input  logic [15:0] statusSet,
  output logic        irqOut,
  output logic        txReqPulse,
  output logic        rraReqPulse,
  output logic        camReqPulse,
  output logic        timerStartPulse,
  output logic        timerStopPulse
);
  strobe_t           stb;
  logic [DATA_W-1:0] cmdQ;
  logic              rbeFlag;

  netc_csr_ctrl u_ctrl (
    .clk, .rstN, .hostWe, .hostAddr, .hostWrData,
    .txDone, .camDone, .rraDone, .rbeFlag,
    .stb, .cmdQ,
    .txReqPulse, .rraReqPulse, .camReqPulse,
    .timerStartPulse, .timerStopPulse
  );

  netc_csr_dp #(.REV_ID(REV_ID), .EOBC_INIT(EOBC_INIT)) u_dp (
    .clk, .rstN, .stb, .wrData(hostWrData), .rdAddr(hostAddr),
    .cmdQ, .statusSet, .rbeFlag, .rdData(hostRdData), .irqOut
  );
endmodule

// File: rtl/netc_csr_bank_chk.sv
module netc_csr_bank_chk #(
  parameter logic [15:0] REV_ID = 16'h0004
) (
  input logic        clk,
  input logic        rstN,
  input logic        hostWe,
  input logic [3:0]  hostAddr,
  input logic        hostWrBit7,
  input logic [15:0] hostRdData,
  input logic        txDone,
  input logic        camDone,
  input logic [15:0] statusSet,
  input logic        irqOut,
  input logic        txReqPulse,
  input logic        rraReqPulse,
  input logic        camReqPulse,
  input logic        timerStartPulse,
  input logic        timerStopPulse,
  input logic        cmdTxp,
  input logic        cmdRxDis,
  input logic        cmdRst
);
  // R2: with no write, no event and no done, the interrupt level holds
  p_irq_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!hostWe && statusSet == 16'h0 && !txDone && !camDone) |=> $stable(irqOut));

  // R5: the revision register always reads its fixed value
  p_rev_fixed_r5: assert property (@(posedge clk) disable iff (!rstN)
    (hostAddr == 4'd14) |-> (hostRdData == REV_ID));

  // R7: the exit-from-reset write clears reset and triggers nothing
  p_reset_exit_r7: assert property (@(posedge clk) disable iff (!rstN)
    (hostWe && hostAddr == 4'd0 && cmdRst && !hostWrBit7) |=>
      (!cmdRst && !txReqPulse && !rraReqPulse && !camReqPulse &&
       !timerStartPulse && !timerStopPulse));

  // R9: a software reset enters reset mode with rx disabled and no requests
  p_soft_reset_r9: assert property (@(posedge clk) disable iff (!rstN)
    (hostWe && hostAddr == 4'd0 && hostWrBit7) |=>
      (cmdRst && cmdRxDis && !cmdTxp && !txReqPulse && !camReqPulse && !rraReqPulse));

  // R10: a transmit request never lasts two cycles
  p_tx_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    txReqPulse |=> !txReqPulse);

  // R11: transmit done drops the pending transmit bit
  p_txdone_clear_r11: assert property (@(posedge clk) disable iff (!rstN)
    txDone |=> !cmdTxp);
endmodule

bind netc_csr_bank netc_csr_bank_chk #(.REV_ID(REV_ID)) u_chk (
  .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostAddr(hostAddr),
  .hostWrBit7(hostWrData[7]), .hostRdData(hostRdData),
  .txDone(txDone), .camDone(camDone), .statusSet(statusSet),
  .irqOut(irqOut), .txReqPulse(txReqPulse), .rraReqPulse(rraReqPulse),
  .camReqPulse(camReqPulse), .timerStartPulse(timerStartPulse),
  .timerStopPulse(timerStopPulse),
  .cmdTxp(cmdQ[1]), .cmdRxDis(cmdQ[2]), .cmdRst(cmdQ[7])
);

// File: tb/netc_csr_bank_bench.sv
`timescale 1ns/1ps
module netc_csr_bank_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWe = 1'b0;
  logic [3:0]  hostAddr = '0;
  logic [15:0] hostWrData = '0;
  logic [15:0] hostRdData;
  logic        txDone = 1'b0, camDone = 1'b0, rraDone = 1'b0;
  logic [15:0] statusSet = '0;
  logic        irqOut, txReqPulse, rraReqPulse, camReqPulse;
  logic        timerStartPulse, timerStopPulse;

  int nChk = 0;
  int nErr = 0;
  logic [15:0] m [16];

  always #10 clk = ~clk;

  netc_csr_bank u_netc_csr_bank (
    .clk, .rstN, .hostWe, .hostAddr, .hostWrData, .hostRdData,
    .txDone, .camDone, .rraDone, .statusSet, .irqOut,
    .txReqPulse, .rraReqPulse, .camReqPulse, .timerStartPulse, .timerStopPulse
  );

  function automatic logic [15:0] wmask(int a);
    case (a)
      1: return 16'hBFFF;
      15: return 16'hF017;
      2: return 16'hFFE0;
      3: return 16'hF000;
      4: return 16'h7FFF;
      6, 7, 8, 9: return 16'hFFFE;
      default: return 16'hFFFF;
    endcase
  endfunction

  task automatic ck(string tag, logic [15:0] act, logic [15:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chkReg(int a, string tag);
    hostAddr = 4'(a);
    #1;
    ck(tag, hostRdData, m[a]);
  endtask

  // one cycle of stimulus; called and returns at a falling edge
  task automatic step(bit we, int a, logic [15:0] d, bit tD, bit cD, bit rD,
                      logic [15:0] ss, string tag);
    logic [15:0] c, v, nIsr;
    logic [4:0]  ep;
    c = m[0]; nIsr = m[5]; ep = '0;
    if (we) begin
      case (a)
        0: begin
          if (m[0][7] && !d[7]) c[7] = 1'b0;
          else begin
            v = d & 16'h03BF;
            c = m[0] | v;
            if (v[2]) c[3] = 1'b0;
            if (v[3]) c[2] = 1'b0;
            if (v[4]) c[5] = 1'b0;
            if (v[5]) c[4] = 1'b0;
            ep[3] = v[5]; ep[4] = v[4];
            if (v[7]) c = (c & ~16'h0303) | 16'h0084;
            else begin
              ep[0] = v[1] && !m[0][1];
              ep[1] = v[8] && !m[0][8];
              ep[2] = v[9] && !m[0][9];
            end
          end
        end
        5: begin
          if (d[5] && m[5][5] && !m[0][8]) begin c[8] = 1'b1; ep[1] = 1'b1; end
          nIsr = m[5] & ~d;
        end
        14: ;
        1, 15: if (m[0][7]) m[a] = d & wmask(a);
        10, 11, 12: m[a] = ~d;
        default: m[a] = d & wmask(a);
      endcase
    end
    nIsr = nIsr | ss | (tD ? 16'h0200 : 16'h0) | (cD ? 16'h1000 : 16'h0);
    if (tD) c[1] = 1'b0;
    if (cD) c[9] = 1'b0;
    if (rD) c[8] = 1'b0;
    hostWe = we; hostAddr = 4'(a); hostWrData = d;
    txDone = tD; camDone = cD; rraDone = rD; statusSet = ss;
    @(posedge clk);
    m[0] = c; m[5] = nIsr;
    @(negedge clk);
    hostWe = 1'b0; txDone = 1'b0; camDone = 1'b0; rraDone = 1'b0; statusSet = '0;
    ck({tag, " pulses"}, 16'({timerStopPulse, timerStartPulse, camReqPulse, rraReqPulse, txReqPulse}),
       16'(ep));
    ck("R2 irq", 16'(irqOut), 16'(|(m[4] & m[5])));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog (all) act=hung exp=finished");
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end

  initial begin : main
    int unsigned seedDummy;
    seedDummy = $urandom(32'd4242);
    for (int i = 0; i < 16; i++) m[i] = 16'h0;
    m[0] = 16'h0094; m[13] = 16'h02F8; m[14] = 16'h0004;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 16; a++) chkReg(a, "R1 reset value");
    ck("R1 pulses", 16'({timerStopPulse, timerStartPulse, camReqPulse, rraReqPulse, txReqPulse}), 16'h0);

    // R5/R6: random writes while still in reset mode
    for (int i = 0; i < 40; i++) begin
      int a;
      a = $urandom_range(1, 15);
      if (a == 5) a = 13;
      step(1'b1, a, 16'($urandom), 0, 0, 0, 16'h0, (a == 1 || a == 15) ? "R6" : "R5");
      chkReg(a, (a == 1 || a == 15) ? "R6 reset-mode write" : "R5 write rule");
    end
    step(1'b1, 14, 16'hFFFF, 0, 0, 0, 16'h0, "R5");
    chkReg(14, "R5 revision read-only");

    // R7 exit from reset
    step(1'b1, 0, 16'h0000, 0, 0, 0, 16'h0, "R7");
    chkReg(0, "R7 exit reset");
    // R6 gate closed
    step(1'b1, 1, 16'h1234, 0, 0, 0, 16'h0, "R6");
    chkReg(1, "R6 write outside reset ignored");
    step(1'b1, 15, 16'hFFFF, 0, 0, 0, 16'h0, "R6");
    chkReg(15, "R6 second config ignored");

    // R10 transmit request and re-request
    step(1'b1, 0, 16'h0002, 0, 0, 0, 16'h0, "R10 first");
    chkReg(0, "R10 pending");
    step(1'b1, 0, 16'h0002, 0, 0, 0, 16'h0, "R10 repeat");
    // R11 done
    step(1'b0, 0, 16'h0, 1, 0, 0, 16'h0, "R11 txDone");
    chkReg(0, "R11 tx cleared");
    chkReg(5, "R11 tx status");

    // R8 orderings
    step(1'b1, 0, 16'h0008, 0, 0, 0, 16'h0, "R8 rxen");
    chkReg(0, "R8 rxen clears rxdis");
    step(1'b1, 0, 16'h0020, 0, 0, 0, 16'h0, "R8 start");
    chkReg(0, "R8 start clears stop");
    step(1'b1, 0, 16'h0014, 0, 0, 0, 16'h0, "R8 stop+rxdis");
    chkReg(0, "R8 stop and rxdis");
    step(1'b1, 0, 16'h0030, 0, 0, 0, 16'h0, "R8 both timer");
    chkReg(0, "R8 both timer bits");

    // R10/R11 resource read and CAM load
    step(1'b1, 0, 16'h0300, 0, 0, 0, 16'h0, "R10 rra+cam");
    chkReg(0, "R10 rra+cam pending");
    step(1'b0, 0, 16'h0, 0, 1, 0, 16'h0, "R11 camDone");
    step(1'b0, 0, 16'h0, 0, 0, 1, 16'h0, "R11 rraDone");
    chkReg(0, "R11 cam/rra cleared");
    chkReg(5, "R11 cam status");

    // R2/R5 mask and W1C
    step(1'b1, 4, 16'hFFFF, 0, 0, 0, 16'h0, "R2 mask");
    chkReg(4, "R5 mask msb");
    step(1'b1, 5, 16'hFFFF, 0, 0, 0, 16'h0, "R3 clear all");
    chkReg(5, "R3 w1c");

    // R4 buffers-exhausted clear issues resource read
    step(1'b0, 0, 16'h0, 0, 0, 0, 16'h0020, "R4 set");
    step(1'b1, 5, 16'h0020, 0, 0, 0, 16'h0, "R4 clear");
    chkReg(0, "R4 rra pending");
    chkReg(5, "R4 status cleared");
    step(1'b0, 0, 16'h0, 0, 0, 1, 16'h0, "R11 rraDone");

    // R3 set wins over clear
    step(1'b0, 0, 16'h0, 0, 0, 0, 16'h0003, "R3 set");
    step(1'b1, 5, 16'h0003, 0, 0, 0, 16'h0002, "R3 mixed");
    chkReg(5, "R3 set wins");

    // R2/R3 random interrupt traffic
    for (int i = 0; i < 60; i++) begin
      int op;
      logic [15:0] ss;
      op = $urandom_range(0, 2);
      ss = ($urandom_range(0, 3) == 0) ? 16'($urandom) : 16'h0;
      if (op == 0) step(1'b0, 0, 16'h0, 0, 0, 0, ss, "R2 event");
      else if (op == 1) step(1'b1, 4, 16'($urandom), 0, 0, 0, ss, "R2 mask");
      else step(1'b1, 5, 16'($urandom), 0, 0, 0, ss, "R3 w1c");
      if (i % 10 == 0) chkReg(5, "R3 random status");
    end
    step(1'b0, 0, 16'h0, 0, 0, 1, 16'h0, "R11 rraDone");

    // R9 software reset
    step(1'b1, 0, 16'h0002, 0, 0, 0, 16'h0, "R10 tx again");
    step(1'b1, 0, 16'h0383, 0, 0, 0, 16'h0, "R9 soft reset");
    chkReg(0, "R9 command after reset");
    // R7 again: exit with a transmit bit written
    step(1'b1, 0, 16'h0202, 0, 0, 0, 16'h0, "R7 exit only");
    chkReg(0, "R7 only reset cleared");

    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end
endmodule